// File: doc/BRIEF.md
# Multi-Format Stereo Audio Serializer

This block turns left/right sample pairs into a three-wire serial stereo stream: a bit clock, a channel-select line and a serial data line. It runs on a master clock at 256 times the sample rate. The bit clock is that clock divided by four, so a frame has 64 bit slots, with 32 slots per channel. The data format and the sample width are set at run time by two plain configuration inputs. The format is I2S, left-justified or right-justified. The width is 16, 20, 24 or 32 bits. Both inputs are meant to be changed only while reset is held.

Sample pairs come in through a valid/ready read port that faces a FIFO. The block is always the consumer. It raises `pair_ready` for exactly one master-clock cycle per frame, in the last cycle before the left channel's data begins. A transfer happens only in a cycle where `pair_ready` and `pair_valid` are both high. At any other time the pair inputs are ignored, and the producer may drop or change `pair_valid` freely. If `pair_valid` is low during the pop cycle, no transfer takes place and the block does not retry until the next frame. The previously held pair is then sent again, so an underflowing FIFO makes the stream repeat the last pair rather than go silent.

Top module: `aser_stereo_tx`

## Requirements
- R1: `sclk` has a period of 4 `mclk` cycles, and 64 periods make one frame of 256 `mclk` cycles. All outputs are registered. On the first `mclk` edge after reset is released, `sclk` still shows the low half of slot 0.
- R2: `lrclk` is low for the 32 slots of the left channel and high for the 32 slots of the right channel. It changes only in the cycle where `sclk` falls.
- R3: `sdout` changes only in the cycle where `sclk` falls, so a receiver samples it on the rising edge. Samples are sent MSB first.
- R4: With `fmt_sel` = 0 (I2S), the MSB of each channel appears in the slot after the `lrclk` change. The last bit of a 32-bit right sample falls in slot 0 of the next frame.
- R5: With `fmt_sel` = 1 (left-justified), and also with the reserved code 3, the MSB of each channel appears in the first slot of that channel's half-frame.
- R6: With `fmt_sel` = 2 (right-justified), the LSB of each channel falls in the last slot of its half-frame, and every slot before the MSB is driven as 0.
- R7: `width_sel` selects W = 16, 20, 24 or 32 bits for codes 0 to 3. Samples are right-aligned on `pair_left`/`pair_right`: bits W-1..0 are sent and bits above W-1 are ignored. In I2S and left-justified modes, the slots after the LSB are 0.
- R8: `pair_ready` is a single-cycle pulse once every 256 `mclk` cycles. Count `mclk` edges from reset release, with the counter showing 0 before the first edge. The pulse falls at count 255 mod 256 in left- and right-justified modes, and at count 3 mod 256 in I2S mode.
- R9: If `pair_valid` is low during the pulse, the next frame re-sends the most recently accepted left and right samples.
- R10: During reset, `sclk`, `lrclk`, `sdout` and `pair_ready` are low. The held pair is zero, so frames sent before the first accepted pair carry all-zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock, 256 x sample rate |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_sel | input | 2 | 0 I2S, 1 left-justified, 2 right-justified, 3 as 1 |
| width_sel | input | 2 | Sample width code: 16/20/24/32 bits |
| pair_valid | input | 1 | FIFO has a pair available |
| pair_ready | output | 1 | Pop strobe, one cycle per frame |
| pair_left | input | 32 | Left sample, right-aligned |
| pair_right | input | 32 | Right sample, right-aligned |
| sclk | output | 1 | Bit clock, mclk / 4 |
| lrclk | output | 1 | Channel select, low = left |
| sdout | output | 1 | Serial data |

## Verification
The bench builds the block with its default parameters: 32 slots per channel and a divide-by-four bit clock. This keeps a frame at 256 cycles, which is short enough to sweep all sixteen combinations of format code and width code, including the reserved format code. For each combination it runs seven frames and predicts every output on every master-clock cycle by arithmetic on the cycle count. The producer model withholds the pair at the first pop and at two consecutive later pops. This brings the all-zero start, single and back-to-back underflow repeats, and the I2S slot that carries the previous frame's right LSB within reach. Sample values have nonzero bits above every width, so any leak of ignored bits shows up.

// File: rtl/aser_pkg.sv
package aser_pkg;

  typedef enum logic [1:0] {
    FMT_I2S   = 2'd0,
    FMT_LEFT  = 2'd1,
    FMT_RIGHT = 2'd2,
    FMT_RSVD  = 2'd3
  } aser_fmt_e;

  // Width code to number of valid sample bits.
  function automatic int width_of(input logic [1:0] code);
    case (code)
      2'd0:    return 16;
      2'd1:    return 20;
      2'd2:    return 24;
      default: return 32;
    endcase
  endfunction

endpackage

// File: rtl/aser_frame_timer.sv
module aser_frame_timer #(
  parameter int DIV_LOG2  = 2,
  parameter int SLOT_LOG2 = 5,
  localparam int FSLOT_W  = SLOT_LOG2 + 1,
  localparam int CNT_W    = FSLOT_W + DIV_LOG2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               i2s_mode,
  output logic               bclk_raw,
  output logic               ws_raw,
  output logic [FSLOT_W-1:0] data_slot,
  output logic               pop_strobe
);

  logic [CNT_W-1:0]   cnt;
  logic [FSLOT_W-1:0] slot;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + 1'b1;
  end

  assign slot      = cnt[CNT_W-1:DIV_LOG2];
  assign bclk_raw  = cnt[DIV_LOG2-1];
  assign ws_raw    = slot[FSLOT_W-1];
  // I2S data lags the channel select by one slot.
  assign data_slot = slot - FSLOT_W'(i2s_mode);
  assign pop_strobe = (&cnt[DIV_LOG2-1:0]) && (&data_slot);

  assert_pop_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pop_strobe |=> !pop_strobe);

endmodule

// File: rtl/aser_pair_hold.sv
module aser_pair_hold #(
  parameter int SAMPLE_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                take,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_left,
  input  logic [SAMPLE_W-1:0] in_right,
  output logic                in_ready,
  output logic [SAMPLE_W-1:0] held_left,
  output logic [SAMPLE_W-1:0] held_right
);

  assign in_ready = take;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_left  <= '0;
      held_right <= '0;
    end else if (in_ready && in_valid) begin
      held_left  <= in_left;
      held_right <= in_right;
    end
  end

  assert_hold_repeat_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && in_valid) |=> ($stable(held_left) && $stable(held_right)));

  assert_hold_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && in_valid) |=> (held_left == $past(in_left) && held_right == $past(in_right)));

endmodule

// File: rtl/aser_bit_pick.sv
module aser_bit_pick #(
  parameter int SLOT_LOG2 = 5,
  localparam int HALF     = 1 << SLOT_LOG2,
  localparam int FSLOT_W  = SLOT_LOG2 + 1
) (
  input  logic [1:0]         fmt,
  input  logic [1:0]         wcode,
  input  logic [FSLOT_W-1:0] data_slot,
  input  logic [HALF-1:0]    left,
  input  logic [HALF-1:0]    right,
  output logic               bit_o
);
  import aser_pkg::*;

  int                   w;
  int                   k;
  logic [HALF-1:0]      smp;
  logic [SLOT_LOG2-1:0] pos;

  always_comb begin
    w     = width_of(wcode);
    k     = int'(data_slot[SLOT_LOG2-1:0]);
    smp   = data_slot[FSLOT_W-1] ? right : left;
    pos   = '0;
    bit_o = 1'b0;
    if (aser_fmt_e'(fmt) == FMT_RIGHT) begin
      if (k >= HALF - w) begin
        pos   = SLOT_LOG2'(HALF - 1 - k);
        bit_o = smp[pos];
      end
    end else if (k < w) begin
      pos   = SLOT_LOG2'(w - 1 - k);
      bit_o = smp[pos];
    end
  end

endmodule

// File: rtl/aser_stereo_tx.sv
module aser_stereo_tx #(
  parameter int DIV_LOG2  = 2,
  parameter int SLOT_LOG2 = 5,
  localparam int SAMPLE_W = 1 << SLOT_LOG2,
  localparam int FSLOT_W  = SLOT_LOG2 + 1
) (
  input  logic                mclk,
  input  logic                rst_n,
  input  logic [1:0]          fmt_sel,
  input  logic [1:0]          width_sel,
  input  logic                pair_valid,
  output logic                pair_ready,
  input  logic [SAMPLE_W-1:0] pair_left,
  input  logic [SAMPLE_W-1:0] pair_right,
  output logic                sclk,
  output logic                lrclk,
  output logic                sdout
);
  import aser_pkg::*;

  logic               bclk_raw;
  logic               ws_raw;
  logic [FSLOT_W-1:0] data_slot;
  logic               pop_strobe;
  logic [SAMPLE_W-1:0] held_l;
  logic [SAMPLE_W-1:0] held_r;
  logic               bit_next;
  logic               i2s_mode;

  assign i2s_mode = (aser_fmt_e'(fmt_sel) == FMT_I2S);

  aser_frame_timer #(.DIV_LOG2(DIV_LOG2), .SLOT_LOG2(SLOT_LOG2)) u_timer (
    .clk        (mclk),
    .rst_n      (rst_n),
    .i2s_mode   (i2s_mode),
    .bclk_raw   (bclk_raw),
    .ws_raw     (ws_raw),
    .data_slot  (data_slot),
    .pop_strobe (pop_strobe)
  );

  aser_pair_hold #(.SAMPLE_W(SAMPLE_W)) u_hold (
    .clk        (mclk),
    .rst_n      (rst_n),
    .take       (pop_strobe),
    .in_valid   (pair_valid),
    .in_left    (pair_left),
    .in_right   (pair_right),
    .in_ready   (pair_ready),
    .held_left  (held_l),
    .held_right (held_r)
  );

  aser_bit_pick #(.SLOT_LOG2(SLOT_LOG2)) u_pick (
    .fmt       (fmt_sel),
    .wcode     (width_sel),
    .data_slot (data_slot),
    .left      (held_l),
    .right     (held_r),
    .bit_o     (bit_next)
  );

  // Output stage: all three lines share one register delay.
  always_ff @(posedge mclk) begin
    if (!rst_n) begin
      sclk  <= 1'b0;
      lrclk <= 1'b0;
      sdout <= 1'b0;
    end else begin
      sclk  <= bclk_raw;
      lrclk <= ws_raw;
      sdout <= bit_next;
    end
  end

  assert_sd_on_fall_R3: assert property (@(posedge mclk) disable iff (!rst_n)
    !$stable(sdout) |-> $fell(sclk));

  assert_ws_on_fall_R2: assert property (@(posedge mclk) disable iff (!rst_n)
    !$stable(lrclk) |-> $fell(sclk));

endmodule

// File: tb/test_aser_stereo_tx.sv
module test_aser_stereo_tx;

  localparam int CYC = 7 * 256 + 4;

  logic        mclk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  fmt_sel = 2'd0;
  logic [1:0]  width_sel = 2'd0;
  logic        pair_valid = 1'b0;
  logic        pair_ready;
  logic [31:0] pair_left = '0;
  logic [31:0] pair_right = '0;
  logic        sclk, lrclk, sdout;

  int vectors = 0;
  int fails = 0;
  int n, pops, vc;
  bit pending, took;
  logic prev_sd, prev_sclk;

  always #5 mclk = ~mclk;

  aser_stereo_tx i_aser_stereo_tx (
    .mclk(mclk), .rst_n(rst_n), .fmt_sel(fmt_sel), .width_sel(width_sel),
    .pair_valid(pair_valid), .pair_ready(pair_ready),
    .pair_left(pair_left), .pair_right(pair_right),
    .sclk(sclk), .lrclk(lrclk), .sdout(sdout)
  );

  function automatic bit avail(input int p);
    return !(p == 0 || p % 5 == 3 || p % 5 == 4);
  endfunction

  function automatic logic [31:0] item_l(input int q);
    return 32'h8000_0001 ^ (32'(q + 1) * 32'h1357_9BDF);
  endfunction

  function automatic logic [31:0] item_r(input int q);
    logic [31:0] a;
    a = item_l(q);
    return {a[15:0], a[31:16]} ^ 32'hF0F0_0F0F;
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s fmt=%0d w=%0d n=%0d actual=%b expected=%b",
               req, fmt_sel, width_sel, n, act, exp);
    end
  endtask

  task automatic drive_fifo();
    pair_valid = avail(pops);
    pair_left  = item_l(vc);
    pair_right = item_r(vc);
  endtask

  // Expected serial bit for master-clock index m (the cycle the outputs reflect).
  task automatic expect_bit(input int m, output logic b, output string req);
    int t, off, dg, g, k, b_i, p, w, vq;
    logic [31:0] l, r, s;
    bit rj;
    t   = m >> 2;
    off = (fmt_sel == 2'd0) ? 1 : 0;
    rj  = (fmt_sel == 2'd2);
    dg  = t - off;
    g   = (dg < 0) ? -1 : dg / 64;
    k   = dg - 64 * g;
    b_i = k % 32;
    p   = g - 1 + off;
    w   = 16 + 4 * int'(width_sel) + ((width_sel == 2'd3) ? 4 : 0);
    l = '0; r = '0; vq = 0;
    for (int q = 0; q <= p; q++) begin
      if (avail(q)) begin l = item_l(vq); r = item_r(vq); vq++; end
    end
    s = (k >= 32) ? r : l;
    b = 1'b0;
    if (rj) begin
      if (b_i >= 32 - w) b = s[31 - b_i];
    end else if (b_i < w) b = s[w - 1 - b_i];
    req = (fmt_sel == 2'd0) ? "R4" : (rj ? "R6" : "R5");
    req = {req, " R7"};
    if (p <= 0) req = {req, " R10"};
    else if (!avail(p)) req = {req, " R9"};
  endtask

  task automatic run_cfg(input int f, input int wc);
    logic  eb;
    string rq;
    int    m;
    fmt_sel = 2'(f); width_sel = 2'(wc);
    rst_n = 1'b0; pops = 0; vc = 0; pending = 0; took = 0;
    drive_fifo();
    repeat (3) @(negedge mclk);
    check("R10 sclk", sclk, 1'b0);
    check("R10 lrclk", lrclk, 1'b0);
    check("R10 sdout", sdout, 1'b0);
    check("R10 ready", pair_ready, 1'b0);
    rst_n = 1'b1; n = 0;
    check("R8 ready", pair_ready, 1'b0);
    prev_sd = sdout; prev_sclk = sclk;
    for (int i = 0; i < CYC; i++) begin
      @(posedge mclk); n++;
      @(negedge mclk);
      m = n - 1;
      check("R1 sclk", sclk, 1'((m >> 1) & 1));
      check("R2 lrclk", lrclk, 1'((m >> 7) & 1));
      expect_bit(m, eb, rq);
      check(rq, sdout, eb);
      if (sdout !== prev_sd) check("R3 edge", prev_sclk & ~sclk, 1'b1);
      check("R8 ready", pair_ready,
            1'((n % 256) == ((f == 0) ? 3 : 255)));
      prev_sd = sdout; prev_sclk = sclk;
      if (pending) begin
        pops++;
        if (took) vc++;
        drive_fifo();
      end
      pending = pair_ready;
      took    = pair_valid;
    end
  endtask

  initial begin
    #(100000 * 10);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    for (int f = 0; f < 4; f++)
      for (int wc = 0; wc < 4; wc++)
        run_cfg(f, wc);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule